// File: doc/BRIEF.md
# One-Shot Event Timer

A 16-bit down counter that runs once per load and raises a timeout flag. It has two clock sources. In cycle mode it counts down once on every system clock. In pulse mode it counts down once for each falling edge seen on an external pulse pin, so it can count events. A control input, driven from bit 5 of the chip's control register, selects the mode.

Software reaches the counter through two byte locations on an 8-bit register bus. A write to the low location fills a holding byte. A write to the high location copies the holding byte and the new high byte into the counter together, arms the timer and clears the flag. When the armed counter counts down past zero, the flag goes high. After that the counter keeps running, but it cannot raise the flag again until software reloads it. Reading the low byte clears the flag. The timer stays idle from reset until the first load.

Top module: `evt_timer`

## Requirements
- R1: After reset the count reads 0 at both offsets and the flag is low. The count then stays at 0 and the flag stays low until the first write to offset 9.
- R2: A write to offset 8 stores the byte in a holding register and leaves the count unchanged. The stored byte becomes the low byte of the next load.
- R3: A write to offset 9 loads count = {written byte, holding byte}, arms the timer and clears the flag. The new count is visible in the cycle after the write.
- R4: With pulse_mode_i = 0, the count falls by one on every clock edge after the load edge.
- R5: With pulse_mode_i = 1, each falling edge of pulse_i lowers the count by exactly one.
  - The edge takes effect on the third clock edge after the pin falls, because the pin passes through a two-stage synchronizer.
  - With no falling edge, the count holds.
- R6: Counting down from 0 wraps the count to 0xFFFF. If the timer is armed, this also sets irq_flag_o on that same edge.
- R7: After the flag has been set once, the counter keeps counting, including further passes through zero. No further pass through zero sets the flag until the next write to offset 9, which re-arms the timer.
- R8: Reads return the counter's low byte at offset 8 and its high byte at offset 9. Every other offset reads 0.
  - A read at offset 8 clears the flag.
  - A read at offset 9, or at any other offset, leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| pulse_mode_i | input | 1 | 1 = count pin edges, 0 = count clocks |
| pulse_i | input | 1 | External pulse pin, asynchronous |
| irq_flag_o | output | 1 | Timeout flag |

## Verification
The hardest case to reach is the lockout. To show it, the counter must pass through zero a second time without a reload, and the flag must stay low. In cycle mode, after the first timeout, the stimulus clears the flag with a low-byte read. It then leaves the counter running for a full 65536-cycle wrap and confirms that the flag stays low. A reload afterwards shows that the timer re-arms. In pulse mode, table rows apply enough edges to run past zero and probe the wrap value. Reads at offset 9 and at an unmapped offset, made while the flag is high, show that those reads do not clear the flag.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int CNT_W  = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] OFF_LO = 4'h8;
  localparam logic [ADDR_W-1:0] OFF_HI = 4'h9;

  typedef struct packed {
    logic              wr_lo;
    logic              wr_hi;
    logic              rd_lo;
    logic [DATA_W-1:0] data;
  } bus_cmd_t;
endpackage

// File: rtl/evt_timer_edge.sv
module evt_timer_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  // idle-high reset so release from reset makes no edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b1;
    else         sync_q[0] <= pin_i;
  end

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[i] <= 1'b1;
      else         sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign fall_o = prev_q & ~sync_q[SYNC_STAGES-1];

  AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o); // R5
endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output bus_cmd_t          cmd_o,
  output logic [DATA_W-1:0] hold_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] hold_q;

  assign cmd_o.wr_lo = wr_i & (addr_i == OFF_LO);
  assign cmd_o.wr_hi = wr_i & (addr_i == OFF_HI);
  assign cmd_o.rd_lo = rd_i & (addr_i == OFF_LO);
  assign cmd_o.data  = wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          hold_q <= '0;
    else if (cmd_o.wr_lo) hold_q <= wdata_i;
  end

  assign hold_o = hold_q;

  always_comb begin
    unique case (addr_i)
      OFF_LO:  rdata_o = cnt_i[DATA_W-1:0];
      OFF_HI:  rdata_o = cnt_i[CNT_W-1:DATA_W];
      default: rdata_o = '0;
    endcase
  end

  AST_HOLD_ONLY_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_o.wr_lo |=> $stable(hold_q)); // R2
endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core
  import evt_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_cmd_t          cmd_i,
  input  logic [DATA_W-1:0] hold_i,
  input  logic              pulse_mode_i,
  input  logic              fall_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              flag_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, armed_q, flag_q;
  logic             tick, fire;

  assign tick = run_q & (pulse_mode_i ? fall_i : 1'b1);
  assign fire = tick & armed_q & (cnt_q == '0);

  // load beats timeout, timeout beats read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
    end else if (cmd_i.wr_hi) begin
      cnt_q   <= {cmd_i.data, hold_i};
      run_q   <= 1'b1;
      armed_q <= 1'b1;
      flag_q  <= 1'b0;
    end else begin
      if (tick) cnt_q <= cnt_q - 1'b1;
      if (fire) begin
        flag_q  <= 1'b1;
        armed_q <= 1'b0;
      end else if (cmd_i.rd_lo) begin
        flag_q  <= 1'b0;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !cmd_i.wr_hi) |=> $stable(cnt_q)); // R1
  AST_LOAD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.wr_hi |=> !flag_q); // R3
  AST_PULSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_mode_i && !fall_i && !cmd_i.wr_hi) |=> $stable(cnt_q)); // R5
  AST_WRAP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> (cnt_q == '1)); // R6
  AST_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(armed_q)); // R7
  AST_RD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.rd_lo && !cmd_i.wr_hi && !fire) |=> !flag_q); // R8
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              pulse_mode_i,
  input  logic              pulse_i,
  output logic              irq_flag_o
);
  bus_cmd_t          cmd;
  logic [DATA_W-1:0] hold;
  logic [CNT_W-1:0]  cnt;
  logic              fall;

  evt_timer_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pulse_i),
    .fall_o(fall)
  );

  evt_timer_regs u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_i),
    .wr_i   (wr_i),
    .rd_i   (rd_i),
    .wdata_i(wdata_i),
    .cnt_i  (cnt),
    .cmd_o  (cmd),
    .hold_o (hold),
    .rdata_o(rdata_o)
  );

  evt_timer_core u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd),
    .hold_i      (hold),
    .pulse_mode_i(pulse_mode_i),
    .fall_i      (fall),
    .cnt_o       (cnt),
    .flag_o      (irq_flag_o)
  );
endmodule

// File: tb/sim_evt_timer.sv
`timescale 1ns/1ps
module sim_evt_timer;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       pmode = 1'b0;
  logic       pin = 1'b1;
  logic       flag;
  int total = 0, bad = 0;
  logic [7:0] got;

  always #2 clk = ~clk;

  evt_timer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .pulse_mode_i(pmode),
    .pulse_i(pin), .irq_flag_o(flag)
  );

  // {lo, hi, pulses, expected count, expected flag}
  localparam logic [47:0] VEC [0:5] = '{
    {8'h34, 8'h12, 8'd3, 16'h1231, 8'd0},
    {8'h02, 8'h00, 8'd2, 16'h0000, 8'd0},
    {8'h02, 8'h00, 8'd3, 16'hFFFF, 8'd1},
    {8'h00, 8'h00, 8'd1, 16'hFFFF, 8'd1},
    {8'h00, 8'h01, 8'd1, 16'h00FF, 8'd0},
    {8'h01, 8'h00, 8'd4, 16'hFFFD, 8'd1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic pulse();
    pin = 1'b0;
    repeat (4) @(negedge clk);
    pin = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state and idle
    chk(flag == 1'b0, "R1 flag", flag, 0);
    rd_reg(4'h8, got); chk(got == 8'h00, "R1 lo", got, 0);
    rd_reg(4'h9, got); chk(got == 8'h00, "R1 hi", got, 0);
    repeat (10) @(negedge clk);
    rd_reg(4'h8, got); chk(got == 8'h00, "R1 idle", got, 0);
    chk(flag == 1'b0, "R1 idle flag", flag, 0);

    // pulse mode table
    pmode = 1'b1;
    for (int i = 0; i < 6; i++) begin
      wr_reg(4'h8, VEC[i][47:40]);
      wr_reg(4'h9, VEC[i][39:32]);
      chk(flag == 1'b0, "R3 clr", flag, 0);
      for (int p = 0; p < int'(VEC[i][31:24]); p++) pulse();
      repeat (6) @(negedge clk);
      chk(flag == VEC[i][0], "R6/R7 flag", flag, VEC[i][0]);
      rd_reg(4'h9, got); chk(got == VEC[i][23:16], "R5 hi", got, VEC[i][23:16]);
      rd_reg(4'h8, got); chk(got == VEC[i][15:8], "R5 lo", got, VEC[i][15:8]);
    end

    // R2 holding byte
    wr_reg(4'h8, 8'h34); wr_reg(4'h9, 8'h12);
    wr_reg(4'h8, 8'h99);
    rd_reg(4'h9, got); chk(got == 8'h12, "R2 hi", got, 8'h12);
    rd_reg(4'h8, got); chk(got == 8'h34, "R2 lo", got, 8'h34);
    wr_reg(4'h9, 8'h00);
    rd_reg(4'h8, got); chk(got == 8'h99, "R2 next load", got, 8'h99);

    // cycle mode: count 5
    pmode = 1'b0;
    wr_reg(4'h8, 8'h05);
    wr_reg(4'h9, 8'h00);            // count = 5 now
    chk(flag == 1'b0, "R3 flag", flag, 0);
    rd_reg(4'h9, got); chk(got == 8'h00, "R3 hi", got, 0);
    rd_reg(4'h8, got); chk(got == 8'h04, "R4 lo", got, 4);
    repeat (3) @(negedge clk);      // count 0
    chk(flag == 1'b0, "R6 at zero", flag, 0);
    @(negedge clk);                 // wrapped
    chk(flag == 1'b1, "R6 set", flag, 1);
    rd_reg(4'h9, got); chk(got == 8'hFF, "R6 wrap hi", got, 8'hFF);
    rd_reg(4'h8, got); chk(got == 8'hFE, "R7 runs", got, 8'hFE);
    chk(flag == 1'b0, "R8 lo clr", flag, 0);
    repeat (65600) @(negedge clk);
    chk(flag == 1'b0, "R7 lockout", flag, 0);

    // rearm
    wr_reg(4'h8, 8'h02);
    wr_reg(4'h9, 8'h00);
    repeat (2) @(negedge clk);
    chk(flag == 1'b0, "R7 rearm pre", flag, 0);
    @(negedge clk);
    chk(flag == 1'b1, "R7 rearm fire", flag, 1);
    rd_reg(4'h9, got);
    chk(flag == 1'b1, "R8 hi keeps", flag, 1);
    rd_reg(4'h5, got); chk(got == 8'h00, "R8 other", got, 0);
    chk(flag == 1'b1, "R8 other keeps", flag, 1);
    rd_reg(4'h8, got);
    chk(flag == 1'b0, "R8 lo clears", flag, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule